// File: doc/BRIEF.md
# Address Break Condition Detector

This debug-support block watches every bus cycle and signals a break when a cycle meets a programmed address condition. It holds two identical, independent channels. Each channel stores a 24-bit break address and an 8-bit control word. The control word selects how many low address bits to ignore, which cycle type (fetch, data read, data write or either data cycle) may match, and whether transfer-controller cycles count. It also holds a sticky match flag and an interrupt enable.

Software programs the channels through a simple byte-wide register port. Reads are combinational and writes take effect at the clock edge. The bus side only observes, so it has no ready signal: a cycle with `bus_valid` high is evaluated in the cycle it appears and is never stalled. A match sets the channel flag at the next clock edge. The flag stays set until software reads the control word with the flag at 1 and then writes it back with bit 7 at 0. The break request goes high whenever a set flag has its enable at 1.

Top module: `brk_detect_top`

## Requirements
- R1: After reset every break address byte and every control word reads 0, both match flags are 0 and `brk_irq` is 0.
- R2: `reg_addr[2]` selects the channel (0 = A, 1 = B). Inside a channel, offsets 0, 1 and 2 hold address bits 7:0, 15:8 and 23:16, and offset 3 holds the control word. The control word has the flag in bit 7, the master select in bit 6, the mask code in bits 5:3, the cycle condition in bits 2:1 and the interrupt enable in bit 0. A read returns the stored value in the same cycle.
- R3: Mask code 0..7 excludes the low 0, 1, 2, 3, 4, 8, 12 or 16 address bits from the comparison. All other bits must equal the break address.
- R4: `bus_kind` is encoded 00 = fetch, 01 = data read, 10 = data write, 11 = reserved. Condition 00 matches only fetches, 01 only reads, 10 only writes, and 11 reads or writes. A reserved kind never matches.
- R5: `bus_dma` = 1 marks a transfer-controller cycle. When master select is 0, only cycles with `bus_dma` = 0 can match. When it is 1, both kinds of cycle can match.
- R6: A qualifying cycle sets the channel's flag at the next clock edge. The flag then stays set, and `match_flag[ch]` always equals control bit 7.
- R7: The flag clears only on a control write with bit 7 = 0 that follows a control read which returned the flag as 1. A write with bit 7 = 1 never changes the flag, and software can never set it.
- R8: Every control write ends the read-as-1 arming. A write of 0 without a prior qualifying read leaves the flag set.
- R9: When a qualifying cycle and a valid clear fall in the same clock cycle, the flag stays set.
- R10: `brk_irq` is high exactly when some channel has its flag at 1 and its enable at 1.
- R11: Register accesses and matches on one channel never change the other channel's flag, arming or registers.
- R12: With `bus_valid` low, no cycle matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_addr | input | 24 | Bus cycle address |
| bus_kind | input | 2 | Cycle type: 00 fetch, 01 read, 10 write |
| bus_dma | input | 1 | 1 when the transfer controller owns the bus |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used to arm a clear) |
| reg_addr | input | 3 | Channel in bit 2, offset in bits 1:0 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| match_flag | output | 2 | Per-channel sticky match flag |
| brk_irq | output | 1 | Combined break interrupt request |

## Verification
The assertions check on every cycle that the request is never raised without a set flag, and that the flags hold when neither a bus strobe nor a register write is present. They also check that a flag rises only after a strobe and falls only after a register write with bit 7 at 0. Only the bench scenarios can show the rest: the mask widths, the cycle and master qualifiers, the read-then-write clear handshake with its arming loss, set-over-clear priority and channel independence. The bench checks these against a behavioural model and against hand-computed expectations.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_RSVD  = 2'b11
  } bus_kind_e;

  // Control word, flag in the MSB.
  typedef struct packed {
    logic       flag;
    logic       any_master;
    logic [2:0] mask_sel;
    logic [1:0] cond;
    logic       ie;
  } ctl_t;

  // Number of low address bits ignored for each mask code.
  function automatic int mask_bits(input logic [2:0] code);
    case (code)
      3'd5:    mask_bits = 8;
      3'd6:    mask_bits = 12;
      3'd7:    mask_bits = 16;
      default: mask_bits = int'(code);
    endcase
  endfunction

endpackage

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  input  logic              from_dma,
  input  logic [ADDR_W-1:0] bar,
  input  ctl_t              ctl,
  output logic              hit
);

  logic [ADDR_W-1:0] keep;
  logic              addr_ok;
  logic              kind_ok;
  logic              master_ok;
  int                low;

  always_comb begin
    low = mask_bits(ctl.mask_sel);
    for (int b = 0; b < ADDR_W; b++) begin
      keep[b] = (b >= low);
    end
  end

  assign addr_ok = (((addr ^ bar) & keep) == '0);

  always_comb begin
    case (ctl.cond)
      2'b00:   kind_ok = (kind == KIND_FETCH);
      2'b01:   kind_ok = (kind == KIND_READ);
      2'b10:   kind_ok = (kind == KIND_WRITE);
      default: kind_ok = (kind == KIND_READ) || (kind == KIND_WRITE);
    endcase
  end

  assign master_ok = !from_dma || ctl.any_master;
  assign hit       = strobe && addr_ok && kind_ok && master_ok;

endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import brk_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int OFS_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic [8*ADDR_BYTES-1:0] bus_addr,
  input  logic [1:0]            bus_kind,
  input  logic                  bus_dma,
  input  logic                  sel,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [OFS_W-1:0]      ofs,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic                  flag,
  output logic                  irq_req
);

  localparam int ADDR_W  = 8 * ADDR_BYTES;
  localparam int CTL_OFS = ADDR_BYTES;

  logic [ADDR_W-1:0] bar_q;
  ctl_t              ctl_q;
  ctl_t              wctl;
  logic              armed_q;
  logic              hit;
  logic              wr_ctl;
  logic              rd_ctl;
  logic              clr;

  assign wctl   = ctl_t'(wdata);
  assign wr_ctl = sel && reg_wr && (ofs == OFS_W'(CTL_OFS));
  assign rd_ctl = sel && reg_rd && (ofs == OFS_W'(CTL_OFS));
  assign clr    = wr_ctl && armed_q && !wctl.flag;

  brk_match #(.ADDR_W(ADDR_W)) match_i (
    .strobe   (bus_valid),
    .addr     (bus_addr),
    .kind     (bus_kind),
    .from_dma (bus_dma),
    .bar      (bar_q),
    .ctl      (ctl_q),
    .hit      (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_q   <= '0;
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      for (int i = 0; i < ADDR_BYTES; i++) begin
        if (sel && reg_wr && (ofs == OFS_W'(i))) begin
          bar_q[i*8 +: 8] <= wdata;
        end
      end
      if (wr_ctl) begin
        ctl_q.any_master <= wctl.any_master;
        ctl_q.mask_sel   <= wctl.mask_sel;
        ctl_q.cond       <= wctl.cond;
        ctl_q.ie         <= wctl.ie;
      end
      ctl_q.flag <= hit || (ctl_q.flag && !clr);
      if (wr_ctl) begin
        armed_q <= 1'b0;
      end else if (rd_ctl && ctl_q.flag) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (ofs == OFS_W'(CTL_OFS)) begin
      rdata = ctl_q;
    end else begin
      for (int i = 0; i < ADDR_BYTES; i++) begin
        if (ofs == OFS_W'(i)) rdata = bar_q[i*8 +: 8];
      end
    end
  end

  assign flag    = ctl_q.flag;
  assign irq_req = ctl_q.flag && ctl_q.ie;

endmodule

// File: rtl/brk_detect_top.sv
module brk_detect_top
  import brk_pkg::*;
#(
  parameter  int NUM_CH     = 2,
  parameter  int ADDR_BYTES = 3,
  localparam int ADDR_W     = 8 * ADDR_BYTES,
  localparam int OFS_W      = $clog2(ADDR_BYTES + 1),
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int REG_AW     = CH_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_kind,
  input  logic              bus_dma,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [NUM_CH-1:0] match_flag,
  output logic              brk_irq
);

  logic [CH_W-1:0]   ch_idx;
  logic [OFS_W-1:0]  ofs;
  logic [7:0]        ch_rdata [NUM_CH];
  logic [NUM_CH-1:0] irq_vec;

  assign ch_idx = reg_addr[REG_AW-1:OFS_W];
  assign ofs    = reg_addr[OFS_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    brk_channel #(
      .ADDR_BYTES (ADDR_BYTES),
      .OFS_W      (OFS_W)
    ) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_kind  (bus_kind),
      .bus_dma   (bus_dma),
      .sel       (ch_idx == CH_W'(g)),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .ofs       (ofs),
      .wdata     (reg_wdata),
      .rdata     (ch_rdata[g]),
      .flag      (match_flag[g]),
      .irq_req   (irq_vec[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == CH_W'(c)) reg_rdata = ch_rdata[c];
    end
  end

  assign brk_irq = |irq_vec;

endmodule

// File: rtl/brk_chk.sv
module brk_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic [NUM_CH-1:0] match_flag,
  input logic              brk_irq
);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> (match_flag != '0));

  // R12
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !reg_wr) |=> $stable(match_flag));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // R6
    rise_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_flag[g]) |-> $past(bus_valid));

    // R7
    fall_after_write0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(match_flag[g]) |-> ($past(reg_wr) && !$past(reg_wdata[7])));
  end

endmodule

bind brk_detect_top brk_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .match_flag (match_flag),
  .brk_irq    (brk_irq)
);

// File: tb/brk_detect_top_tb_top.sv
`timescale 1ns/1ps
module brk_detect_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [1:0]  bus_kind = '0;
  logic        bus_dma = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [1:0]  match_flag;
  logic        brk_irq;

  always #2.5 clk = ~clk;

  brk_detect_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_addr   (bus_addr),
    .bus_kind   (bus_kind),
    .bus_dma    (bus_dma),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .match_flag (match_flag),
    .brk_irq    (brk_irq)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [23:0] m_bar [2];
  logic [7:0]  m_ctl [2];
  bit          m_arm [2];
  logic [7:0]  last_rdata;

  localparam logic [1:0] FETCH = 2'b00, RD = 2'b01, WR = 2'b10, RSV = 2'b11;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_hit(input int ch);
    logic [23:0] keep;
    int          n;
    bit          kind_ok;
    logic [7:0]  c;
    c = m_ctl[ch];
    case (c[5:3])
      3'd5: n = 8;
      3'd6: n = 12;
      3'd7: n = 16;
      default: n = int'(c[5:3]);
    endcase
    keep = 24'hFFFFFF << n;
    case (c[2:1])
      2'b00: kind_ok = (bus_kind == FETCH);
      2'b01: kind_ok = (bus_kind == RD);
      2'b10: kind_ok = (bus_kind == WR);
      default: kind_ok = (bus_kind == RD) || (bus_kind == WR);
    endcase
    return bus_valid && ((bus_addr & keep) == (m_bar[ch] & keep)) && kind_ok
           && (!bus_dma || c[6]);
  endfunction

  task automatic idle();
    bus_valid = 1'b0; bus_dma = 1'b0; bus_kind = FETCH; bus_addr = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0; reg_addr = '0;
  endtask

  // One cycle: inputs already driven; model steps alongside the design.
  task automatic tick();
    logic [7:0] nctl [2];
    bit         narm [2];
    logic [23:0] nbar [2];
    int sel, ofs;
    logic [7:0] exp_rd;
    sel = int'(reg_addr[2]);
    ofs = int'(reg_addr[1:0]);
    #1;
    if (reg_rd) begin
      exp_rd = (ofs == 3) ? m_ctl[sel] : m_bar[sel][ofs*8 +: 8];
      last_rdata = reg_rdata;
      chk("R2 read data", reg_rdata, exp_rd);
    end
    for (int ch = 0; ch < 2; ch++) begin
      bit wrc, rdc, clr, h;
      wrc = reg_wr && sel == ch && ofs == 3;
      rdc = reg_rd && sel == ch && ofs == 3;
      clr = wrc && m_arm[ch] && !reg_wdata[7];
      h = model_hit(ch);
      nctl[ch] = m_ctl[ch];
      if (wrc) nctl[ch][6:0] = reg_wdata[6:0];
      nctl[ch][7] = h || (m_ctl[ch][7] && !clr);
      narm[ch] = wrc ? 1'b0 : ((rdc && m_ctl[ch][7]) ? 1'b1 : m_arm[ch]);
      nbar[ch] = m_bar[ch];
      if (reg_wr && sel == ch && ofs < 3) nbar[ch][ofs*8 +: 8] = reg_wdata;
    end
    @(posedge clk);
    for (int ch = 0; ch < 2; ch++) begin
      m_ctl[ch] = nctl[ch]; m_arm[ch] = narm[ch]; m_bar[ch] = nbar[ch];
    end
    @(negedge clk);
    chk("R6 flag vector vs model", match_flag, {m_ctl[1][7], m_ctl[0][7]});
    chk("R10 irq vs model", brk_irq,
        (m_ctl[0][7] && m_ctl[0][0]) || (m_ctl[1][7] && m_ctl[1][0]));
    idle();
  endtask

  task automatic wr(input int ch, input int ofs, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = {ch[0], ofs[1:0]}; reg_wdata = d; tick();
  endtask

  task automatic rd(input int ch, input int ofs);
    reg_rd = 1'b1; reg_addr = {ch[0], ofs[1:0]}; tick();
  endtask

  task automatic cyc(input logic v, input logic [23:0] a, input logic [1:0] k, input logic d);
    bus_valid = v; bus_addr = a; bus_kind = k; bus_dma = d; tick();
  endtask

  task automatic clear(input int ch, input logic [7:0] c);
    rd(ch, 3); wr(ch, 3, c & 8'h7F);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    report();
    $finish;
  end

  initial begin
    for (int ch = 0; ch < 2; ch++) begin m_bar[ch] = '0; m_ctl[ch] = '0; m_arm[ch] = 0; end
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags after reset", match_flag, 2'b00);
    chk("R1 irq after reset", brk_irq, 1'b0);
    rd(0, 3); chk("R1 ctl A reset", last_rdata, 8'h00);
    rd(1, 2); chk("R1 addr B reset", last_rdata, 8'h00);

    // R2 programming
    wr(0, 0, 8'h56); wr(0, 1, 8'h34); wr(0, 2, 8'h12); wr(0, 3, 8'h01);
    rd(0, 1); chk("R2 addr byte1", last_rdata, 8'h34);
    rd(0, 3); chk("R2 ctl A", last_rdata, 8'h01);

    // R6 fetch match
    cyc(1, 24'h123456, FETCH, 0);
    chk("R6 flag A set", match_flag[0], 1'b1);
    chk("R10 irq on", brk_irq, 1'b1);
    cyc(0, 24'h0, FETCH, 0);
    chk("R6 flag sticky", match_flag[0], 1'b1);

    // R8 write 0 without read
    wr(0, 3, 8'h01); chk("R8 unarmed write keeps flag", match_flag[0], 1'b1);
    // R7 write 1 no effect
    rd(0, 3); chk("R2 ctl reads flag", last_rdata, 8'h81);
    wr(0, 3, 8'h81); chk("R7 write1 keeps flag", match_flag[0], 1'b1);
    clear(0, 8'h01);
    chk("R7 clear after read", match_flag[0], 1'b0);
    chk("R10 irq off", brk_irq, 1'b0);
    wr(0, 3, 8'h81); chk("R7 cannot set flag", match_flag[0], 1'b0);

    // R4 conditions
    cyc(1, 24'h123456, RD, 0); chk("R4 fetch cond ignores read", match_flag[0], 1'b0);
    wr(0, 3, 8'h07);
    cyc(1, 24'h123456, FETCH, 0); chk("R4 rw cond ignores fetch", match_flag[0], 1'b0);
    cyc(1, 24'h123456, RSV, 0); chk("R4 reserved kind", match_flag[0], 1'b0);
    cyc(1, 24'h123456, WR, 0); chk("R4 rw cond write", match_flag[0], 1'b1);
    clear(0, 8'h07);
    cyc(1, 24'h123456, RD, 0); chk("R4 rw cond read", match_flag[0], 1'b1);
    clear(0, 8'h05);
    cyc(1, 24'h123456, RD, 0); chk("R4 write cond ignores read", match_flag[0], 1'b0);
    cyc(1, 24'h123456, WR, 0); chk("R4 write cond", match_flag[0], 1'b1);
    clear(0, 8'h03);

    // R3 masks
    wr(0, 3, 8'h23);
    cyc(1, 24'h12345F, RD, 0); chk("R3 mask4 hit", match_flag[0], 1'b1);
    clear(0, 8'h23);
    cyc(1, 24'h123466, RD, 0); chk("R3 mask4 miss", match_flag[0], 1'b0);
    wr(0, 3, 8'h2B);
    cyc(1, 24'h1234FF, RD, 0); chk("R3 mask8 hit", match_flag[0], 1'b1);
    clear(0, 8'h2B);
    cyc(1, 24'h1235FF, RD, 0); chk("R3 mask8 miss", match_flag[0], 1'b0);
    wr(0, 3, 8'h3B);
    cyc(1, 24'h12ABCD, RD, 0); chk("R3 mask16 hit", match_flag[0], 1'b1);
    clear(0, 8'h3B);
    cyc(1, 24'h13ABCD, RD, 0); chk("R3 mask16 miss", match_flag[0], 1'b0);
    wr(0, 3, 8'h0B);
    cyc(1, 24'h123457, RD, 0); chk("R3 mask1 hit", match_flag[0], 1'b1);
    clear(0, 8'h03);

    // R5 master select
    cyc(1, 24'h123456, RD, 1); chk("R5 cpu-only ignores dma", match_flag[0], 1'b0);
    wr(0, 3, 8'h43);
    cyc(1, 24'h123456, RD, 1); chk("R5 any master dma", match_flag[0], 1'b1);
    clear(0, 8'h43);
    cyc(1, 24'h123456, RD, 0); chk("R5 any master cpu", match_flag[0], 1'b1);
    clear(0, 8'h03);

    // R12 strobe low
    cyc(0, 24'h123456, RD, 0); chk("R12 no strobe no match", match_flag[0], 1'b0);

    // R10 enable gating
    wr(0, 3, 8'h02);
    cyc(1, 24'h123456, RD, 0);
    chk("R10 flag set with ie=0", match_flag[0], 1'b1);
    chk("R10 irq masked", brk_irq, 1'b0);
    wr(0, 3, 8'h03);
    chk("R8 enable write keeps flag", match_flag[0], 1'b1);
    chk("R10 irq after enable", brk_irq, 1'b1);

    // R9 set wins over clear
    rd(0, 3);
    reg_wr = 1'b1; reg_addr = 3'b011; reg_wdata = 8'h03;
    bus_valid = 1'b1; bus_addr = 24'h123456; bus_kind = RD; tick();
    chk("R9 set beats clear", match_flag[0], 1'b1);
    wr(0, 3, 8'h03); chk("R8 arming lost after write", match_flag[0], 1'b1);
    clear(0, 8'h03); chk("R7 clear", match_flag[0], 1'b0);

    // R11 channel independence
    wr(1, 0, 8'hEF); wr(1, 1, 8'hCD); wr(1, 2, 8'hAB); wr(1, 3, 8'h01);
    cyc(1, 24'hABCDEF, FETCH, 0);
    chk("R11 B set", match_flag, 2'b10);
    wr(0, 3, 8'h01);
    cyc(1, 24'h123456, FETCH, 0);
    chk("R11 both set", match_flag, 2'b11);
    rd(1, 3);
    wr(0, 3, 8'h01); chk("R11 B read does not arm A", match_flag, 2'b11);
    wr(1, 3, 8'h01); chk("R11 B armed clears alone", match_flag, 2'b01);
    rd(0, 0); chk("R11 A addr intact", last_rdata, 8'h56);
    clear(0, 8'h01); chk("R11 all clear", match_flag, 2'b00);

    report();
    $finish;
  end

endmodule